// File: doc/BRIEF.md
# Periodic Interrupt and Status Flag Controller

This block generates the periodic interrupt of a real-time-clock style peripheral and keeps its interrupt status byte. Software reaches it through a byte-wide register port with four locations: a rate/time-base control register, a general control register, a status register, and a fixed validity register.

A 4-bit rate code and a 3-bit time-base field set the interrupt frequency. While the enable bit is set, a countdown clocked by the system clock fires once per period. Each firing raises the interrupt line and records a periodic flag. The update-ended and alarm events come from outside as one-cycle pulses. They only set their status flags. The status register is cleared by reading it, and that read also lowers the interrupt line.

The period in system-clock cycles is `CLK_HZ` divided by the selected frequency. The frequency is a power of two, so the period is `CLK_HZ` shifted right.

Top module: `rtc_pirq_ctrl`

## Requirements
- R1: After reset the interrupt output is low and locations 0, 1 and 2 all read 0x00.
- R2: With rate codes 3 to 15 and the enable bit set, successive interrupts are CLK_HZ / 2^(16 - code) system-clock cycles apart, whatever the time base.
- R3: For rate codes 1 and 2, the frequency is 2^(9 - code) Hz when the time-base field (location 0 bits 6:4) is 3'b010. It is 2^(16 - code) Hz when that field is 3'b000 or 3'b001. Any other field value keeps the time base chosen before it. After reset the time base is the 3'b000/3'b001 kind.
- R4: Rate code 0 produces no interrupt and no periodic flag, even with the enable bit set.
- R5: A write to location 0 stores bits 6:0 (rate code in 3:0, time base in 6:4), and bit 7 reads back as 0. The write restarts the countdown, so the next interrupt comes exactly one new period after the write edge.
- R6: Location 1 stores the whole written byte, and its bit 6 is the periodic enable. A write that changes bit 6 restarts the countdown, so the first interrupt after enabling comes one period after the write edge. A write with bit 6 clear lowers the interrupt output and stops further periodic interrupts.
- R7: When the countdown expires, the interrupt output goes high and status bit 6 (periodic flag) is set. The countdown restarts without losing phase, so the next expiry comes exactly one period after the previous one even if the status is read in between.
- R8: Status bit 7 is set whenever any of bit 4 (update flag), bit 5 (alarm flag) or bit 6 is set. `upd_pulse` sets bit 4 and `alm_pulse` sets bit 5, and neither one changes the interrupt output.
- R9: A read of location 2 returns the current status byte, then clears it to 0x00 and lowers the interrupt output.
- R10: An event pulse in the same cycle as a read of location 2 survives the clear, so the next read shows its flag.
- R11: Location 3 always reads 0x80 (bit 7 is the valid flag). Writes to locations 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Location: 0 rate/time base, 1 control, 2 status, 3 validity |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe, 0 otherwise |
| upd_pulse | input | 1 | One-cycle update-ended event |
| alm_pulse | input | 1 | One-cycle alarm event |
| irq | output | 1 | Periodic interrupt request, high until cleared |

## Verification
The assertions assume the bus strobe lasts exactly one cycle per access, and that the event pulses are single-cycle and synchronous to the clock. The bench drives every access and every pulse for a single cycle from the falling edge. The properties also assume `CLK_HZ` is at least 65536, so every period is at least two cycles. The bench keeps that bound and measures the interrupt spacing for fast and slow time bases on both the shortest and the longest periods. Coincident cases (a read against an event, a disable against a pending interrupt) are driven on purpose, and only after the status has been cleared, so every expected byte is known in advance.

// File: rtl/rtc_pirq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the periodic interrupt controller.
// Assumes a 2-bit location select and byte-wide data.
package rtc_pirq_pkg;

    typedef enum logic [1:0] {
        LOC_RATE   = 2'd0,
        LOC_CTRL   = 2'd1,
        LOC_STATUS = 2'd2,
        LOC_VALID  = 2'd3
    } loc_e;

    localparam int EN_BIT    = 6;  // control: periodic enable
    localparam int ANY_BIT   = 7;  // status: summary flag
    localparam int PER_BIT   = 6;  // status: periodic flag
    localparam int ALM_BIT   = 5;  // status: alarm flag
    localparam int UPD_BIT   = 4;  // status: update flag
    localparam int VALID_BIT = 7;  // validity register

    localparam logic [2:0] TB_FAST_A = 3'b000;
    localparam logic [2:0] TB_FAST_B = 3'b001;
    localparam logic [2:0] TB_SLOW   = 3'b010;

    // Log2 of the interrupt frequency for a rate code and time base.
    function automatic logic [4:0] freq_log2(input logic [3:0] code, input logic slow);
        if (slow && (code < 4'd3))
            return 5'd9 - {1'b0, code};
        return 5'd16 - {1'b0, code};
    endfunction

endpackage

// File: rtl/rtc_rate_decode.sv
`timescale 1ns/1ps
// Turns a rate code and time-base choice into a period in clock cycles.
// Assumes CLK_HZ >= 65536 so every non-zero code gives a period >= 2.
// Code 0 yields a zero period, which the timer treats as disabled.
module rtc_rate_decode #(
    parameter int CLK_HZ = 1048576,
    parameter int CNT_W  = 20
) (
    input  logic [3:0]       code,
    input  logic             slow,
    output logic [CNT_W-1:0] period
);
    import rtc_pirq_pkg::*;

    logic [4:0] shamt;

    // Select the frequency exponent, then shift the clock rate down.
    always_comb begin
        shamt  = freq_log2(code, slow);
        period = '0;
        if (code != 4'd0)
            period = CNT_W'(CLK_HZ >> shamt);
    end
endmodule

// File: rtl/rtc_period_timer.sv
`timescale 1ns/1ps
// Countdown that fires once per period while running.
// Assumes period >= 2 whenever run is high and period is non-zero.
// A reload takes precedence over counting and suppresses a firing.
module rtc_period_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] period,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;
    logic             active;

    // Decide whether the count advances and whether it expires now.
    always_comb begin
        active = run && (period != '0) && !reload;
        fire   = active && (cnt_q <= CNT_W'(1));
    end

    // Load, reload on expiry to keep phase, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= reload_val;
        else if (fire)
            cnt_q <= period;
        else if (active)
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/rtc_status_flags.sv
`timescale 1ns/1ps
// Status byte with read-to-clear flags and the interrupt line.
// Assumes events are single-cycle pulses. An event in the cycle of a
// clearing read is kept.
module rtc_status_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_evt,
    input  logic       alm_evt,
    input  logic       per_evt,
    input  logic       rd_clr,
    input  logic       irq_drop,
    output logic [7:0] status,
    output logic       irq
);
    import rtc_pirq_pkg::*;

    logic [2:0] flags_q;   // {per, alm, upd}
    logic       any_q;
    logic [2:0] flags_d;

    // Next flag set: clear on read, then merge new events.
    always_comb begin
        flags_d = (rd_clr ? 3'b000 : flags_q) | {per_evt, alm_evt, upd_evt};
    end

    // Hold the flags and the summary bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            any_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            any_q   <= |flags_d;
        end
    end

    // Interrupt line: set by a periodic firing, dropped by read or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (per_evt)
            irq <= 1'b1;
        else if (rd_clr || irq_drop)
            irq <= 1'b0;
    end

    // Assemble the status byte.
    always_comb begin
        status          = 8'h00;
        status[ANY_BIT] = any_q;
        status[PER_BIT] = flags_q[2];
        status[ALM_BIT] = flags_q[1];
        status[UPD_BIT] = flags_q[0];
    end
endmodule

// File: rtl/rtc_pirq_ctrl.sv
`timescale 1ns/1ps
// Periodic interrupt controller: register port, rate decode, timer and status.
// Assumes one-cycle access strobes. Read data is combinational for the
// cycle of the strobe.
module rtc_pirq_ctrl #(
    parameter int CLK_HZ = 1048576
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       upd_pulse,
    input  logic       alm_pulse,
    output logic       irq
);
    import rtc_pirq_pkg::*;

    localparam int CNT_W = $clog2(CLK_HZ / 2 + 1);

    logic [3:0]       rate_q;
    logic [2:0]       tb_q;
    logic             slow_q;
    logic [7:0]       ctrl_q;
    logic             wr_rate, wr_ctrl, rd_stat;
    logic             slow_d, en_flip;
    logic [CNT_W-1:0] period_cur, period_new, reload_val;
    logic             reload, prd_fire;
    logic [7:0]       stat_c;

    // Decode the access strobes.
    always_comb begin
        wr_rate = bus_sel && bus_wr && (bus_addr == LOC_RATE);
        wr_ctrl = bus_sel && bus_wr && (bus_addr == LOC_CTRL);
        rd_stat = bus_sel && !bus_wr && (bus_addr == LOC_STATUS);
    end

    // Time base chosen by the written field; unknown codes keep the old one.
    always_comb begin
        slow_d = slow_q;
        if (bus_wdata[6:4] == TB_SLOW)
            slow_d = 1'b1;
        else if ((bus_wdata[6:4] == TB_FAST_A) || (bus_wdata[6:4] == TB_FAST_B))
            slow_d = 1'b0;
    end

    // Rate/time-base register and derived time-base flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            tb_q   <= '0;
            slow_q <= 1'b0;
        end else if (wr_rate) begin
            rate_q <= bus_wdata[3:0];
            tb_q   <= bus_wdata[6:4];
            slow_q <= slow_d;
        end
    end

    // Control register, whole byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= bus_wdata;
    end

    // Period for the stored setting and for the setting being written.
    rtc_rate_decode #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dec_cur (
        .code   (rate_q),
        .slow   (slow_q),
        .period (period_cur)
    );

    rtc_rate_decode #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dec_new (
        .code   (bus_wdata[3:0]),
        .slow   (slow_d),
        .period (period_new)
    );

    // Restart the countdown on a rate write or an enable change.
    always_comb begin
        en_flip    = wr_ctrl && (bus_wdata[EN_BIT] != ctrl_q[EN_BIT]);
        reload     = wr_rate || en_flip;
        reload_val = wr_rate ? period_new : period_cur;
    end

    rtc_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q[EN_BIT]),
        .reload     (reload),
        .reload_val (reload_val),
        .period     (period_cur),
        .fire       (prd_fire)
    );

    rtc_status_flags u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_evt  (upd_pulse),
        .alm_evt  (alm_pulse),
        .per_evt  (prd_fire),
        .rd_clr   (rd_stat),
        .irq_drop (wr_ctrl && !bus_wdata[EN_BIT]),
        .status   (stat_c),
        .irq      (irq)
    );

    // Read mux, zero outside a read cycle.
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                LOC_RATE:   bus_rdata = {1'b0, tb_q, rate_q};
                LOC_CTRL:   bus_rdata = ctrl_q;
                LOC_STATUS: bus_rdata = stat_c;
                default:    bus_rdata = 8'h80;
            endcase
        end
    end
endmodule

// File: rtl/rtc_pirq_chk.sv
`timescale 1ns/1ps
// Property checker for rtc_pirq_ctrl, attached by bind.
// Assumes one-cycle strobes and single-cycle event pulses.
module rtc_pirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       upd_pulse,
    input logic       alm_pulse,
    input logic       irq,
    input logic       fire,
    input logic       en,
    input logic [7:0] stat
);
    logic rd_s, wr_c, wr_s, quiet;
    always_comb begin
        rd_s  = bus_sel && !bus_wr && (bus_addr == 2'd2);
        wr_c  = bus_sel && bus_wr && (bus_addr == 2'd1);
        wr_s  = bus_sel && bus_wr && (bus_addr >= 2'd2);
        quiet = !upd_pulse && !alm_pulse && !fire;
    end

    p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd3) |-> bus_rdata == 8'h80);

    p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_s |-> (bus_rdata[7] == (|bus_rdata[6:4])));

    p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (irq && stat[6]));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && quiet) |=> (stat == 8'h00 && !irq));

    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && upd_pulse) |=> stat[4]);

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && !bus_wdata[6]) |=> !irq);

    p_no_fire_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !fire);

    p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && quiet) |=> $stable(stat));
endmodule

bind rtc_pirq_ctrl rtc_pirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .upd_pulse (upd_pulse),
    .alm_pulse (alm_pulse),
    .irq       (irq),
    .fire      (prd_fire),
    .en        (ctrl_q[6]),
    .stat      (stat_c)
);

// File: tb/sim_rtc_pirq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue expected values, the monitor compares.
module sim_rtc_pirq_ctrl;
    localparam int CLK_HZ = 65536;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_pulse = 1'b0, alm_pulse = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    rtc_pirq_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_pulse(upd_pulse), .alm_pulse(alm_pulse), .irq(irq)
    );

    // Driver side: queue an expected item.
    task automatic expect_item(input string req, input int val);
        exp_t e;
        e.req = req;
        e.val = val;
        exp_q.push_back(e);
    endtask

    // Monitor side: pop and compare an observed result.
    task automatic observe(input int act);
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (act != e.val) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", e.req, act, e.val);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        expect_item(req, exp);
        observe(act);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input bit u, input bit a);
        @(negedge clk);
        upd_pulse = u; alm_pulse = a;
        @(posedge clk); #1;
        upd_pulse = 1'b0; alm_pulse = 1'b0;
    endtask

    // Expected period from the requirement formula.
    function automatic int exp_period(input int code, input bit slow);
        int hz;
        hz = (slow && code < 3) ? (1 << (9 - code)) : (1 << (16 - code));
        return CLK_HZ / hz;
    endfunction

    // Count rising edges until irq goes high, starting from count n.
    task automatic wait_irq(inout int n, input int limit);
        while (!irq && n < limit) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    // Enable with a given rate setting and measure two firings.
    task automatic measure(input string req, input logic [7:0] aval, input int p);
        logic [7:0] v;
        int n;
        reg_write(2'd1, 8'h00);
        reg_read(2'd2, v);
        reg_write(2'd0, aval);
        reg_write(2'd1, 8'h40);
        n = 0;
        wait_irq(n, p + 20);
        check({req, " first period (R6)"}, n, p);
        reg_read(2'd2, v);
        n++;
        check("R7 status after firing", v, 8'hC0);
        check("R9 irq after status read", irq, 0);
        wait_irq(n, 2 * p + 20);
        check("R7 phase kept across read", n, 2 * p);
        reg_read(2'd2, v);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", irq, 0);
        reg_read(2'd0, v); check("R1 loc0", v, 8'h00);
        reg_read(2'd1, v); check("R1 loc1", v, 8'h00);
        reg_read(2'd2, v); check("R1 loc2", v, 8'h00);
        // R11 validity and ignored writes
        reg_read(2'd3, v); check("R11 loc3", v, 8'h80);
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, v); check("R11 loc3 after write", v, 8'h80);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, v); check("R11 loc2 after write", v, 8'h00);
        // R5 readback masks bit 7; time base 111 keeps the fast base
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, v); check("R5 loc0 readback", v, 8'h7F);
        // R4 code 0 gives nothing
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h40);
        repeat (300) @(posedge clk);
        #1 check("R4 irq with code 0", irq, 0);
        reg_read(2'd2, v); check("R4 status with code 0", v, 8'h00);
        // R2 and R3 period measurements
        measure("R2 code3", 8'h03, exp_period(3, 0));
        measure("R2 code6", 8'h26, exp_period(6, 1));
        measure("R3 fast code1", 8'h01, exp_period(1, 0));
        measure("R3 fast code2", 8'h12, exp_period(2, 0));
        measure("R3 slow code1", 8'h21, exp_period(1, 1));
        measure("R3 slow code2", 8'h22, exp_period(2, 1));
        measure("R3 kept slow code1", 8'h71, exp_period(1, 1));
        measure("R2 code15", 8'h0F, exp_period(15, 0));
        // R5 rate write restarts the countdown
        reg_write(2'd1, 8'h00);
        reg_read(2'd2, v);
        reg_write(2'd0, 8'h03);
        reg_write(2'd1, 8'h40);
        repeat (4) @(posedge clk);
        reg_write(2'd0, 8'h04);
        n = 0;
        wait_irq(n, 60);
        check("R5 period after rate write", n, exp_period(4, 0));
        reg_read(2'd0, v); check("R5 loc0 value", v, 8'h04);
        reg_read(2'd1, v); check("R6 loc1 readback", v, 8'h40);
        // R6 disable drops irq and stops firing
        reg_write(2'd1, 8'h00);
        check("R6 irq after disable", irq, 0);
        reg_read(2'd2, v);
        repeat (100) @(posedge clk);
        #1 check("R6 irq stays low", irq, 0);
        reg_read(2'd2, v); check("R6 no periodic flag", v, 8'h00);
        // R8 external events set flags only
        pulse(1, 0);
        check("R8 irq after update", irq, 0);
        reg_read(2'd2, v); check("R8 update flag", v, 8'h90);
        pulse(0, 1);
        reg_read(2'd2, v); check("R8 alarm flag", v, 8'hA0);
        pulse(1, 1);
        reg_read(2'd2, v); check("R8 both flags", v, 8'hB0);
        // R10 event during clearing read is kept
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2; upd_pulse = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; upd_pulse = 1'b0;
        check("R10 read value", v, 8'h00);
        reg_read(2'd2, v); check("R10 flag kept", v, 8'h90);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule